// File: doc/BRIEF.md
# Drive Spindle Motor Idle Timeout Manager

This block keeps track of the spindle motors of up to four disk drives that share one controller. It assembles the 8-bit output control byte seen by the drive cable and the controller. That byte carries the motor enables, the selected drive number, the active-low controller reset line (held inactive) and the interrupt/transfer enable (held on). Each access request names one unit. The block starts that unit's motor, makes it the selected unit and restarts its idle count.

A slow tick, nominally once per second, ages every running drive that is not held. Once a unit has been idle for the configured number of ticks (two by default), its motor bit drops. A per-unit hold input freezes a unit's idle count, for example while the operation waits on a shared transfer channel. If the unit that times out is the selected one and the controller reports an operation still in progress, the block raises a one-cycle recovery pulse so that the surrounding logic can reset the controller. When an access finds a stopped motor, a one-cycle spin-up pulse tells the sequencer to wait for the motor before it seeks.

Top module: `mtr_idle_mgr`

## Requirements
- R1: After a synchronous reset the control byte reads 0x0C (no motor, unit 0 selected, reset line inactive, enable on), and neither pulse output is high.
- R2: Control byte layout: bits 1:0 hold the selected unit number, bit 2 is 1 (reset inactive), bit 3 is 1 (interrupt/transfer enable), and bit 4+u is the motor enable of unit u for u = 0..3.
- R3: An access to unit u sets motor bit 4+u and makes u the selected unit. Both are visible in the cycle after the clock edge that samples the access. The motor bits of other units do not change.
- R4: An access to a unit whose motor is off gives a spin-up pulse lasting exactly one cycle, in the same cycle as the motor bit rises. An access to a unit that is already running gives no pulse.
- R5: Each tick advances the idle count of every running unit whose hold is low. On the second such tick after the unit's last access, its motor bit clears. The control byte shows this in the cycle after that tick.
- R6: While a unit's hold input is high, ticks do not advance its idle count and cannot stop its motor. After hold is released, counting resumes from the value it held.
- R7: An access to a unit clears its idle count, so a fresh run of two ticks is needed before it stops.
- R8: The recovery output pulses high for one cycle, in the same cycle as the motor bit drop, only when the unit that timed out was the selected unit before that edge and busy was high with the tick. There is no pulse when busy is low or when the unit that timed out is not the selected one.
- R9: When an access and a tick fall in the same cycle, the access wins for the accessed unit: its count restarts and it cannot time out. The recovery decision still uses the selection held before that edge.
- R10: Ticks while a unit's motor is off have no effect on the control byte or on either pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_valid | input | 1 | Access request strobe, one cycle per request |
| acc_unit | input | 2 | Unit number of the access |
| tick | input | 1 | Slow aging tick, one cycle wide |
| busy | input | 1 | High while the controller has an operation in progress |
| hold | input | 4 | Per-unit freeze of the idle count |
| dor | output | 8 | Drive control byte (layout in R2) |
| spinup | output | 1 | One-cycle pulse: motor of an accessed unit was started |
| recover | output | 1 | One-cycle pulse: selected unit timed out while busy |

## Verification
An access and a tick can land in the same cycle. This can happen on the unit being accessed, or on the previously selected unit while a different unit is being accessed. The bench provokes both cases. It ages a unit to one tick short of timeout, then applies a tick together with an access, first to that same unit and then to another unit while busy is high. A behavioural model judges every cycle: the access must win for its own unit, and recovery must follow the selection that was in force before the edge.

// File: rtl/mtr_pkg.sv
// Package: shared field positions of the drive control byte.
// Assumes at most four units, so the select field is two bits wide.
package mtr_pkg;
    localparam int SEL_FIELD_W = 2;  // width of the selected-unit field
    localparam int SEL_LSB     = 0;  // selected unit at bits 1:0
    localparam int RST_N_BIT   = 2;  // controller reset, active low
    localparam int IRQ_EN_BIT  = 3;  // interrupt / transfer enable
    localparam int MOTOR_LSB   = 4;  // motor enable of unit 0
    localparam int MAX_UNITS   = 4;
endpackage

// File: rtl/mtr_unit_timer.sv
// Module: per-unit motor state and idle counter.
// The motor starts on access and stops after TIMEOUT unheld ticks with no access.
// Assumes TIMEOUT >= 1 and TIMEOUT fits in CNT_W bits; an access beats a tick.
module mtr_unit_timer #(
    parameter int CNT_W   = 3,
    parameter int TIMEOUT = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic access_i,
    input  logic tick_i,
    input  logic hold_i,
    output logic motor_o,
    output logic expire_o
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(TIMEOUT - 1);

    logic [CNT_W-1:0] cnt_q;
    logic             motor_q;
    logic             age;

    // Purpose: decide whether this tick ages the unit and whether it expires.
    always_comb begin
        age      = tick_i & motor_q & ~hold_i & ~access_i;
        expire_o = age & (cnt_q == LAST);
    end

    // Purpose: update the motor state and the idle count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            motor_q <= 1'b0;
        end else if (access_i) begin
            cnt_q   <= '0;
            motor_q <= 1'b1;
        end else if (expire_o) begin
            cnt_q   <= '0;
            motor_q <= 1'b0;
        end else if (age) begin
            cnt_q   <= cnt_q + 1'b1;
        end
    end

    assign motor_o = motor_q;

    // R6: a held unit with no access keeps its count across the edge
    a_r6_hold_freezes: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_i && !access_i) |=> (cnt_q == $past(cnt_q)));

    // R7: an access restarts the count and leaves the motor running
    a_r7_access_clears: assert property (@(posedge clk) disable iff (!rst_n)
        access_i |=> (cnt_q == '0 && motor_q));

    // R5: the idle count never reaches the timeout value
    a_r5_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q < CNT_W'(TIMEOUT));

    // R10: a stopped motor only restarts through an access
    a_r10_off_stays: assert property (@(posedge clk) disable iff (!rst_n)
        (!motor_q && !access_i) |=> !motor_q);
endmodule

// File: rtl/mtr_dor_build.sv
// Module: packs the drive control byte from the selected unit and motor bits.
// Purely combinational, so the byte follows any motor change in the same cycle.
module mtr_dor_build
    import mtr_pkg::*;
#(
    parameter int NUM_UNITS = 4,
    parameter int SEL_W     = 2,
    parameter int DOR_W     = MOTOR_LSB + NUM_UNITS
) (
    input  logic [SEL_W-1:0]     sel_i,
    input  logic [NUM_UNITS-1:0] motor_i,
    output logic [DOR_W-1:0]     dor_o
);
    // Purpose: place each field at its fixed position.
    always_comb begin
        dor_o = '0;
        dor_o[SEL_LSB +: SEL_FIELD_W]    = SEL_FIELD_W'(sel_i);
        dor_o[RST_N_BIT]                 = 1'b1;
        dor_o[IRQ_EN_BIT]                = 1'b1;
        dor_o[MOTOR_LSB +: NUM_UNITS]    = motor_i;
    end
endmodule

// File: rtl/mtr_recover_gen.sv
// Module: raises a one-cycle recovery pulse when the selected unit expires while busy.
// Assumes sel_i is the selection before the current edge's access.
module mtr_recover_gen #(
    parameter int NUM_UNITS = 4,
    parameter int SEL_W     = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_UNITS-1:0] expire_i,
    input  logic [SEL_W-1:0]     sel_i,
    input  logic                 busy_i,
    output logic                 recover_o
);
    logic hit;

    // Purpose: check whether the selected unit expires in this cycle.
    always_comb begin
        hit = 1'b0;
        for (int u = 0; u < NUM_UNITS; u++) begin
            if (sel_i == SEL_W'(u) && expire_i[u]) hit = 1'b1;
        end
    end

    // Purpose: register the recovery pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) recover_o <= 1'b0;
        else        recover_o <= hit & busy_i;
    end

    // R8: recovery needs busy high on the expiring edge
    a_r8_needs_busy: assert property (@(posedge clk) disable iff (!rst_n)
        recover_o |-> $past(busy_i));

    // R8: the pulse is one cycle wide
    a_r8_single: assert property (@(posedge clk) disable iff (!rst_n)
        recover_o |=> !recover_o);
endmodule

// File: rtl/mtr_idle_mgr.sv
// Module: top of the motor idle timeout manager.
// Holds the selected unit, instantiates one timer per unit and builds the control byte.
// Assumes one access per cycle and NUM_UNITS <= 4.
module mtr_idle_mgr
    import mtr_pkg::*;
#(
    parameter int NUM_UNITS     = 4,
    parameter int CNT_W         = 3,
    parameter int TIMEOUT_TICKS = 2,
    localparam int SEL_W        = (NUM_UNITS > 1) ? $clog2(NUM_UNITS) : 1,
    localparam int DOR_W        = MOTOR_LSB + NUM_UNITS
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 acc_valid,
    input  logic [SEL_W-1:0]     acc_unit,
    input  logic                 tick,
    input  logic                 busy,
    input  logic [NUM_UNITS-1:0] hold,
    output logic [DOR_W-1:0]     dor,
    output logic                 spinup,
    output logic                 recover
);
    logic [SEL_W-1:0]     sel_q;
    logic [NUM_UNITS-1:0] access_vec;
    logic [NUM_UNITS-1:0] motor;
    logic [NUM_UNITS-1:0] expire;
    logic                 spin_d;
    logic                 spin_q;

    // Purpose: decode the access into one strobe per unit and detect a stopped motor.
    always_comb begin
        spin_d = 1'b0;
        for (int u = 0; u < NUM_UNITS; u++) begin
            access_vec[u] = acc_valid && (acc_unit == SEL_W'(u));
            if (access_vec[u] && !motor[u]) spin_d = 1'b1;
        end
    end

    // Purpose: hold the selected unit and register the spin-up pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q  <= '0;
            spin_q <= 1'b0;
        end else begin
            if (acc_valid) sel_q <= acc_unit;
            spin_q <= spin_d;
        end
    end

    for (genvar g = 0; g < NUM_UNITS; g++) begin : g_unit
        mtr_unit_timer #(
            .CNT_W   (CNT_W),
            .TIMEOUT (TIMEOUT_TICKS)
        ) i_timer (
            .clk      (clk),
            .rst_n    (rst_n),
            .access_i (access_vec[g]),
            .tick_i   (tick),
            .hold_i   (hold[g]),
            .motor_o  (motor[g]),
            .expire_o (expire[g])
        );
    end

    mtr_recover_gen #(
        .NUM_UNITS (NUM_UNITS),
        .SEL_W     (SEL_W)
    ) i_recover (
        .clk       (clk),
        .rst_n     (rst_n),
        .expire_i  (expire),
        .sel_i     (sel_q),
        .busy_i    (busy),
        .recover_o (recover)
    );

    mtr_dor_build #(
        .NUM_UNITS (NUM_UNITS),
        .SEL_W     (SEL_W),
        .DOR_W     (DOR_W)
    ) i_dor (
        .sel_i   (sel_q),
        .motor_i (motor),
        .dor_o   (dor)
    );

    assign spinup = spin_q;

    // R4: a spin-up pulse coincides with a motor bit that just rose
    a_r4_spin_with_rise: assert property (@(posedge clk) disable iff (!rst_n)
        spinup |-> ((motor & ~$past(motor)) != '0));

    // R3: the selection follows the sampled access
    a_r3_sel_follows: assert property (@(posedge clk) disable iff (!rst_n)
        $past(acc_valid) |-> (sel_q == $past(acc_unit)));

    // R3: at most one motor can start per edge
    a_r3_one_start: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(motor & ~$past(motor)) <= 1);
endmodule

// File: tb/test_mtr_idle_mgr.sv
`timescale 1ns/1ps
module test_mtr_idle_mgr;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       acc_valid;
    logic [1:0] acc_unit;
    logic       tick;
    logic       busy;
    logic [3:0] hold;
    logic [7:0] dor;
    logic       spinup;
    logic       recover;

    int checks = 0;
    int errors = 0;
    string tag = "R1";

    // behavioural reference state
    int m_cnt [4];
    bit m_mot [4];
    int m_sel;
    bit m_rec;
    bit m_spin;

    always #2.5 clk = ~clk;

    mtr_idle_mgr i_mtr_idle_mgr (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_unit(acc_unit),
        .tick(tick), .busy(busy), .hold(hold), .dor(dor),
        .spinup(spinup), .recover(recover)
    );

    // reference model, advanced on every rising edge
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int u = 0; u < 4; u++) begin m_cnt[u] = 0; m_mot[u] = 0; end
            m_sel = 0; m_rec = 0; m_spin = 0;
        end else begin
            m_rec = 0; m_spin = 0;
            for (int u = 0; u < 4; u++) begin
                if (acc_valid && acc_unit == u) begin
                    if (!m_mot[u]) m_spin = 1;
                    m_mot[u] = 1; m_cnt[u] = 0;
                end else if (tick && m_mot[u] && !hold[u]) begin
                    m_cnt[u]++;
                    if (m_cnt[u] >= 2) begin
                        m_mot[u] = 0; m_cnt[u] = 0;
                        if (u == m_sel && busy) m_rec = 1;
                    end
                end
            end
            if (acc_valid) m_sel = acc_unit;
        end
    end

    function automatic logic [7:0] exp_dor();
        logic [7:0] d;
        d = 8'h0C;
        d[1:0] = 2'(m_sel);
        for (int u = 0; u < 4; u++) d[4+u] = m_mot[u];
        return d;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        chk({tag, " dor"}, 32'(dor), 32'(exp_dor()));
        chk({tag, " spinup"}, 32'(spinup), 32'(m_spin));
        chk({tag, " recover"}, 32'(recover), 32'(m_rec));
    endtask

    // drive one cycle of stimulus, then compare after the edge
    task automatic step(input bit v, input int u, input bit t, input bit b, input logic [3:0] h);
        acc_valid = v; acc_unit = 2'(u); tick = t; busy = b; hold = h;
        @(negedge clk);
        compare_all();
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(0, 0, 0, 0, 4'h0);
    endtask

    initial begin
        rst_n = 0; acc_valid = 0; acc_unit = 0; tick = 0; busy = 0; hold = 0;
        repeat (3) @(negedge clk);
        tag = "R1";
        chk("R1 reset dor", 32'(dor), 32'h0C);
        chk("R1 reset spinup", 32'(spinup), 0);
        chk("R1 reset recover", 32'(recover), 0);
        rst_n = 1;
        idle(1);

        // R3 R4: start unit 0, then R5 timeout without busy
        tag = "R4";
        step(1, 0, 0, 0, 4'h0);
        chk("R3 dor after access u0", 32'(dor), 32'h1C);
        chk("R4 spinup on stopped motor", 32'(spinup), 1);
        idle(1);
        chk("R4 spinup one cycle", 32'(spinup), 0);
        step(1, 0, 0, 0, 4'h0);
        chk("R4 no spinup when running", 32'(spinup), 0);
        tag = "R5";
        step(0, 0, 1, 0, 4'h0);
        chk("R5 one tick keeps motor", 32'(dor), 32'h1C);
        step(0, 0, 1, 0, 4'h0);
        chk("R5 second tick stops motor", 32'(dor), 32'h0C);
        chk("R8 no recovery when not busy", 32'(recover), 0);

        // R8: selected unit times out while busy
        tag = "R8";
        step(1, 1, 0, 0, 4'h0);
        chk("R2 layout unit1", 32'(dor), 32'h2D);
        step(0, 0, 1, 1, 4'h0);
        step(0, 0, 1, 1, 4'h0);
        chk("R8 recovery pulse", 32'(recover), 1);
        chk("R8 motor drop same cycle", 32'(dor), 32'h0D);
        step(0, 0, 0, 1, 4'h0);
        chk("R8 pulse ends", 32'(recover), 0);

        // R8: non-selected unit times out while busy
        step(1, 0, 0, 0, 4'h0);
        step(1, 1, 0, 0, 4'h0);
        step(0, 0, 1, 1, 4'h2);
        step(0, 0, 1, 1, 4'h2);
        chk("R8 other unit no recovery", 32'(recover), 0);
        chk("R8 held selected unit stays", 32'(dor), 32'h2D);

        // R6: hold freezes and resumes
        tag = "R6";
        step(1, 2, 0, 0, 4'h0);
        step(0, 0, 1, 0, 4'h0);
        for (int i = 0; i < 5; i++) step(0, 0, 1, 0, 4'h4);
        chk("R6 held unit keeps motor", 32'(dor[6]), 1);
        step(0, 0, 1, 0, 4'h0);
        chk("R6 resumes from stored count", 32'(dor[6]), 0);

        // R7: access restarts the count
        tag = "R7";
        step(1, 3, 0, 0, 4'h0);
        step(0, 0, 1, 0, 4'h0);
        step(1, 3, 0, 0, 4'h0);
        step(0, 0, 1, 0, 4'h0);
        chk("R7 count restarted", 32'(dor[7]), 1);
        step(0, 0, 1, 0, 4'h0);
        chk("R7 stops after fresh run", 32'(dor[7]), 0);

        // R9: access and tick in the same cycle
        tag = "R9";
        step(1, 2, 0, 0, 4'h0);
        step(0, 0, 1, 1, 4'h0);
        step(1, 2, 1, 1, 4'h0);
        chk("R9 access wins for same unit", 32'(dor[6]), 1);
        chk("R9 no recovery on access win", 32'(recover), 0);
        step(0, 0, 1, 1, 4'h0);
        step(1, 3, 1, 1, 4'h0);
        chk("R9 recovery uses prior selection", 32'(recover), 1);
        chk("R9 new selection and motors", 32'(dor), 32'h8F);

        // R10: ticks with no motor running
        tag = "R10";
        step(0, 0, 1, 0, 4'h0);
        step(0, 0, 1, 0, 4'h0);
        chk("R10 all stopped", 32'(dor), 32'h0F);
        for (int i = 0; i < 4; i++) step(0, 0, 1, 1, 4'h0);
        chk("R10 ticks ignored", 32'(dor), 32'h0F);
        chk("R10 no pulses", 32'({spinup, recover}), 0);

        // R1: reset from a busy state
        tag = "R1";
        step(1, 1, 0, 0, 4'h0);
        rst_n = 0;
        step(0, 0, 0, 0, 4'h0);
        chk("R1 reset again", 32'(dor), 32'h0C);
        rst_n = 1;
        idle(2);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule